// File: doc/BRIEF.md
# Selectable Delayed Trigger Pulse Generator

This block drives a single trigger line from one of several internal logic sources. It runs in one clock domain (nominally 100 MHz), and a 4-bit code picks the source. The candidate sources are:

- a data-ready line;
- data-ready lines qualified by a range flag;
- four per-ASIC discriminator OR lines;
- the OR of all four discriminator lines.

Codes that are not assigned yield a constant low.

Two modes are available. In pass-through mode the trigger line simply follows the chosen source. In delayed mode a rising edge of the chosen source starts a 32-bit cycle countdown. When the countdown ends, the block emits a pulse of fixed width and then holds a guard gap before it accepts another edge. This gives downstream logic a clean, predictable trigger whatever the shape of the source signal.

Top module: `trig_pulse_gen`

## Requirements
- R1: Select code 0 routes `src_dr1` to the output in pass-through mode.
- R2: Code 1 routes `src_rng1 & src_dr1`; code 2 routes `src_rng2 & src_dr2`.
- R3: Codes 8, 9, 10 and 11 route `src_or[0]`, `src_or[1]`, `src_or[2]` and `src_or[3]` respectively.
- R4: Code 12 routes the OR of all four bits of `src_or`.
- R5: Every other code (3 to 7, 13 to 15) gives a constant low output, whatever the source inputs are.
- R6: With `delay_mode` = 0, `trig_out` equals the selected source level in the same cycle, with no register in between.
- R7: With `delay_mode` = 1, a rising edge of the selected source that is seen in cycle n, while the block is idle, raises `trig_out` in cycle n+1+D, where D is `delay_cycles`. D = 0 gives a pulse in the very next cycle.
- R8: In delayed mode each pulse is high for exactly 4 consecutive cycles.
- R9: In delayed mode at least 10 low cycles separate the end of one pulse from the start of the next.
- R10: In delayed mode, rising edges that arrive during the countdown, the pulse or the guard gap are ignored. A source held high produces only one pulse.
- R11: A synchronous active-high `rst` forces `trig_out` low and discards any countdown or pulse in progress.
- R12: Clearing `delay_mode` abandons any pending delayed pulse. After the mode is set again, only a fresh edge can produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_dr1 | input | 1 | Data-ready of ASIC 1 |
| src_rng1 | input | 1 | Range flag of ASIC 1 |
| src_dr2 | input | 1 | Data-ready of ASIC 2 |
| src_rng2 | input | 1 | Range flag of ASIC 2 |
| src_or | input | 4 | Per-ASIC discriminator OR lines |
| sel_code | input | 4 | Source select code |
| delay_mode | input | 1 | 0 = pass-through, 1 = delayed fixed pulse |
| delay_cycles | input | 32 | Delay in clock cycles |
| trig_out | output | 1 | Trigger output |

## Verification
The hardest situation to reach is an edge that lands exactly on a state boundary. Examples are an edge in the final guard-gap cycle, an edge one cycle after the gap ends, or a mode or reset change while a countdown is half finished.

The stimulus reaches these boundaries by driving a source that toggles with a period shorter than the pulse-plus-gap window, under several delays. Over the run the edges slide across every phase of the window. Separate sequences assert reset and clear the mode in the middle of a long countdown, then check that no stray pulse appears afterwards.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int TRIG_N_ASIC = 4;
    localparam int TRIG_SEL_W  = 4;

    localparam logic [TRIG_SEL_W-1:0] SEL_DR1     = 4'd0;
    localparam logic [TRIG_SEL_W-1:0] SEL_RDR1    = 4'd1;
    localparam logic [TRIG_SEL_W-1:0] SEL_RDR2    = 4'd2;
    localparam int                    SEL_OR_BASE = 8;
    localparam logic [TRIG_SEL_W-1:0] SEL_OR_ALL  = 4'd12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PULSE,
        ST_GAP
    } trig_state_e;

    typedef struct packed {
        logic                   dr1;
        logic                   rng1;
        logic                   dr2;
        logic                   rng2;
        logic [TRIG_N_ASIC-1:0] orl;
    } trig_src_t;

endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux
    import trig_pkg::*;
(
    input  trig_src_t             src,
    input  logic [TRIG_SEL_W-1:0] code,
    output logic                  level
);
    logic [TRIG_N_ASIC-1:0] or_hit;

    genvar g;
    generate
        for (g = 0; g < TRIG_N_ASIC; g++) begin : g_or
            assign or_hit[g] = (code == TRIG_SEL_W'(SEL_OR_BASE + g)) & src.orl[g];
        end
    endgenerate

    always_comb begin
        if (code == SEL_DR1)
            level = src.dr1;
        else if (code == SEL_RDR1)
            level = src.rng1 & src.dr1;
        else if (code == SEL_RDR2)
            level = src.rng2 & src.dr2;
        else if (code == SEL_OR_ALL)
            level = |src.orl;
        else
            level = |or_hit;
    end
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/trig_delay_fsm.sv
module trig_delay_fsm
    import trig_pkg::*;
#(
    parameter int DLY_W     = 32,
    parameter int PULSE_LEN = 4,
    parameter int GAP_LEN   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             rise,
    input  logic [DLY_W-1:0] delay,
    output logic             pulse
);
    localparam logic [DLY_W-1:0] PULSE_LAST = DLY_W'(PULSE_LEN - 1);
    localparam logic [DLY_W-1:0] GAP_LAST   = DLY_W'(GAP_LEN - 1);

    trig_state_e      state;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rise) begin
                        cnt   <= (delay == '0) ? '0 : delay - 1'b1;
                        state <= (delay == '0) ? ST_PULSE : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) state <= ST_PULSE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_PULSE: begin
                    if (cnt == PULSE_LAST) begin
                        cnt   <= '0;
                        state <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == GAP_LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pulse = (state == ST_PULSE);
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
    import trig_pkg::*;
#(
    parameter int DLY_W     = 32,
    parameter int PULSE_LEN = 4,
    parameter int GAP_LEN   = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   src_dr1,
    input  logic                   src_rng1,
    input  logic                   src_dr2,
    input  logic                   src_rng2,
    input  logic [TRIG_N_ASIC-1:0] src_or,
    input  logic [TRIG_SEL_W-1:0]  sel_code,
    input  logic                   delay_mode,
    input  logic [DLY_W-1:0]       delay_cycles,
    output logic                   trig_out
);
    trig_src_t src;
    logic      sel_level;
    logic      sel_rise;
    logic      dly_pulse;

    assign src = '{dr1: src_dr1, rng1: src_rng1, dr2: src_dr2, rng2: src_rng2, orl: src_or};

    trig_src_mux u_mux (
        .src   (src),
        .code  (sel_code),
        .level (sel_level)
    );

    trig_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sel_level),
        .rise  (sel_rise)
    );

    trig_delay_fsm #(
        .DLY_W     (DLY_W),
        .PULSE_LEN (PULSE_LEN),
        .GAP_LEN   (GAP_LEN)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .enable (delay_mode),
        .rise   (sel_rise),
        .delay  (delay_cycles),
        .pulse  (dly_pulse)
    );

    assign trig_out = rst ? 1'b0 : (delay_mode ? dly_pulse : sel_level);
endmodule

// File: rtl/trig_pulse_gen_chk.sv
module trig_pulse_gen_chk
    import trig_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    parameter int GAP_LEN   = 10
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   src_dr1,
    input logic [TRIG_SEL_W-1:0]  sel_code,
    input logic                   delay_mode,
    input logic                   trig_out
);
    logic [7:0] hi_run;
    logic [7:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst) hi_run <= '0;
        else     hi_run <= trig_out ? hi_run + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !delay_mode) lo_run <= 8'(GAP_LEN);
        else if (trig_out)      lo_run <= '0;
        else if (lo_run != 8'hFF) lo_run <= lo_run + 1'b1;
    end

    // R8: a delayed pulse ends only after exactly PULSE_LEN high cycles
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(trig_out) && delay_mode && $past(delay_mode)) |-> (hi_run == 8'(PULSE_LEN)));

    // R9: a delayed pulse starts only after the guard gap
    p_gap_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(trig_out) && delay_mode && $past(delay_mode)) |-> (lo_run >= 8'(GAP_LEN)));

    // R11: reset holds the output low
    p_reset_low_r11: assert property (@(posedge clk) rst |-> !trig_out);

    // R1: code 0 in pass-through mode mirrors the data-ready line
    p_direct_dr1_r1: assert property (@(posedge clk) disable iff (rst)
        (!delay_mode && sel_code == SEL_DR1) |-> (trig_out == src_dr1));

    // R5: unassigned codes in pass-through mode stay low
    p_unused_low_r5: assert property (@(posedge clk) disable iff (rst)
        (!delay_mode && ((sel_code >= 4'd3 && sel_code <= 4'd7) || sel_code >= 4'd13)) |-> !trig_out);
endmodule

bind trig_pulse_gen trig_pulse_gen_chk #(
    .PULSE_LEN (PULSE_LEN),
    .GAP_LEN   (GAP_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_dr1    (src_dr1),
    .sel_code   (sel_code),
    .delay_mode (delay_mode),
    .trig_out   (trig_out)
);

// File: tb/trig_pulse_gen_tb.sv
module trig_pulse_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dr1 = 0, rng1 = 0, dr2 = 0, rng2 = 0;
    logic [3:0]  orl = '0;
    logic [3:0]  sel = '0;
    logic        dmode = 1'b0;
    logic [31:0] dly = '0;
    logic        trig_out;

    int     n_cmp = 0;
    int     n_bad = 0;
    string  cur_req = "R11";
    longint cyc_n = 0;
    longint p_start = -1000;
    longint free_at = 0;
    bit     prev_lvl = 0;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    trig_pulse_gen u_dut (
        .clk(clk), .rst(rst), .src_dr1(dr1), .src_rng1(rng1), .src_dr2(dr2),
        .src_rng2(rng2), .src_or(orl), .sel_code(sel), .delay_mode(dmode),
        .delay_cycles(dly), .trig_out(trig_out)
    );

    // source selection taken from R1 to R5
    function automatic bit ref_level();
        case (sel)
            4'd0:  return dr1;
            4'd1:  return rng1 & dr1;
            4'd2:  return rng2 & dr2;
            4'd8:  return orl[0];
            4'd9:  return orl[1];
            4'd10: return orl[2];
            4'd11: return orl[3];
            4'd12: return |orl;
            default: return 1'b0;
        endcase
    endfunction

    // cycle model: called after inputs are set for this cycle
    task automatic chk();
        bit lvl;
        bit exp;
        #2;
        lvl = ref_level();
        if (rst) begin
            exp = 0; p_start = -1000; free_at = 0; lvl = 0;
        end else if (!dmode) begin
            exp = lvl; p_start = -1000; free_at = 0;
        end else begin
            if (lvl && !prev_lvl && cyc_n >= free_at) begin
                p_start = cyc_n + 1 + longint'(dly);
                free_at = p_start + 4 + 10;
            end
            exp = (cyc_n >= p_start && cyc_n < p_start + 4);
        end
        prev_lvl = lvl;
        n_cmp++;
        if (trig_out !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: trig_out=%b expected %b", cur_req, cyc_n, trig_out, exp);
        end
        cyc_n++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); chk();
        end
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state
        cur_req = "R11";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); dr1 = i[0]; chk();
        end
        @(negedge clk); rst = 0; dr1 = 0; chk();

        // R1 / R6: code 0 pass-through
        cur_req = "R1";
        sel = 4'd0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); step_lf(); dr1 = lf[0]; rng1 = lf[1]; chk();
        end
        // R6: same-cycle follow, toggling every cycle
        cur_req = "R6";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); dr1 = i[0]; chk();
        end

        // R2: range-qualified codes
        cur_req = "R2";
        for (int c = 1; c <= 2; c++) begin
            for (int i = 0; i < 16; i++) begin
                @(negedge clk); sel = 4'(c);
                dr1 = i[0]; rng1 = i[1]; dr2 = i[2]; rng2 = i[3]; chk();
            end
        end

        // R3: per-ASIC OR lines
        cur_req = "R3";
        for (int c = 8; c <= 11; c++) begin
            for (int i = 0; i < 16; i++) begin
                @(negedge clk); sel = 4'(c); orl = 4'(i); chk();
            end
        end

        // R4: OR of all
        cur_req = "R4";
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); sel = 4'd12; orl = 4'(i); chk();
        end

        // R5: unassigned codes with all sources high
        cur_req = "R5";
        for (int c = 3; c < 16; c++) begin
            if (c >= 8 && c <= 12) continue;
            @(negedge clk); sel = 4'(c);
            dr1 = 1; rng1 = 1; dr2 = 1; rng2 = 1; orl = 4'hF; chk();
            @(negedge clk); dr1 = 0; orl = 4'h0; chk();
        end

        // R7: delayed mode, D = 0 then D = 5 and D = 37
        cur_req = "R7";
        @(negedge clk); sel = 0; dr1 = 0; rng1 = 0; dr2 = 0; rng2 = 0; orl = 0;
        dmode = 1; dly = 0; chk();
        idle(3);
        @(negedge clk); dr1 = 1; chk();
        @(negedge clk); dr1 = 0; chk();
        idle(20);
        @(negedge clk); dly = 5; dr1 = 1; chk();
        idle(2);
        @(negedge clk); dr1 = 0; chk();
        idle(25);
        // R8: width check with a long delay and an ASIC OR source
        cur_req = "R8";
        @(negedge clk); sel = 4'd9; dly = 37; orl = 4'b0010; chk();
        idle(60);
        @(negedge clk); orl = 0; chk();
        idle(5);

        // R10: held level and extra edges during delay, pulse and gap
        cur_req = "R10";
        @(negedge clk); sel = 0; dly = 3; dr1 = 1; chk();
        idle(30);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); dr1 = ~dr1; chk();
        end

        // R9: edge trains of several periods under several delays
        cur_req = "R9";
        for (int d = 0; d < 4; d++) begin
            for (int per = 2; per <= 7; per++) begin
                @(negedge clk); dly = 32'(d); dr1 = 0; chk();
                for (int i = 0; i < 60; i++) begin
                    @(negedge clk); dr1 = ((i % per) == 0); chk();
                end
                idle(20);
            end
        end

        // R11: reset during a countdown discards the pending pulse
        cur_req = "R11";
        @(negedge clk); dly = 20; dr1 = 1; chk();
        idle(8);
        @(negedge clk); rst = 1; chk();
        @(negedge clk); rst = 0; chk();
        idle(30);
        @(negedge clk); dr1 = 0; chk();
        idle(3);

        // R12: leaving delayed mode abandons a pending pulse
        cur_req = "R12";
        @(negedge clk); dly = 30; dr1 = 1; chk();
        @(negedge clk); dr1 = 0; chk();
        idle(10);
        @(negedge clk); dmode = 0; chk();
        idle(3);
        @(negedge clk); dmode = 1; chk();
        idle(40);
        @(negedge clk); dly = 1; dr1 = 1; chk();
        idle(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule